// File: doc/BRIEF.md
# TRS Word Aligner and Flagger

This block sits behind a deserializer that delivers video words with an unknown bit phase. Each clock brings `LANES` words of `DW` bits on `din`; bit 0 is the earliest bit on the wire, and lane 0 (the low `DW` bits) is the earlier word. The block searches every bit phase of the recent input for the start of a timing reference sequence: an all-ones word followed by two all-zeros words. When it finds one, it moves the word boundary so that the all-ones word lands in lane 0 of the aligned output.

Realignment happens only while `frame_en` is high. Logic outside the block can drop `frame_en` to stop a lone sequence at a wrong phase from moving the boundary. A flag stage looks at the aligned stream itself and marks every word that belongs to a sequence. It also marks the fourth word, the XYZ word, as either an end-of-active-video or a start-of-active-video code. Data and flags leave the block together after a fixed delay.

Top module: `trs_word_aligner`

## Requirements
- R1: While `frame_en` is high, a detected sequence moves the word boundary to its bit phase. Its all-ones word appears in lane 0 of `dout`, and the words after it keep that boundary.
- R2: While `frame_en` is low, the boundary is held. A sequence at another bit phase then leaves no flags and does not change how `dout` is cut.
- R3: `trs[j]` is high exactly when the word in lane j of `dout` is one of the four words of a sequence (all-ones, zero, zero, XYZ). Lane 0 holds bits `DW-1:0` and is the earlier word.
- R4: `eav[j]` and `sav[j]` are high only when lane j carries an XYZ word. The word is an EAV when its bit 6 is 1 and an SAV when its bit 6 is 0. At most one strobe is high in any cycle.
- R5: After reset the offset is zero, and `dout`, `trs`, `eav` and `sav` are all zero until sequences arrive. A sequence that lands word-aligned at offset zero is flagged even with `frame_en` low.
- R6: Aligned data reach `dout` after a fixed delay. At offset zero, the group sampled at one clock edge appears five edges later. The flags share the cycle of their words.
- R7: A sequence is found at every bit phase from 0 to `DW*LANES-1`.
- R8: While the boundary is held at a word phase, a sequence whose all-ones word falls in lane 1 is still flagged, with its XYZ strobe in lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_en | input | 1 | Allows realignment to a newly detected sequence |
| din | input | DW*LANES | Raw deserialized bits, bit 0 earliest |
| dout | output | DW*LANES | Aligned words, lane 0 in the low bits |
| trs | output | LANES | Per-lane marker for words inside a sequence |
| eav | output | LANES | Per-lane strobe on an XYZ word with bit 6 set |
| sav | output | LANES | Per-lane strobe on an XYZ word with bit 6 clear |

## Verification
The assertions assume that sequences in the bit stream never overlap, so the search finds at most one preamble in two consecutive cycles. They also assume `LANES` is between 2 and 4, so two XYZ words can never share one output group. The stimulus builds every line from whole sequences separated by blanking and active words. It never uses the all-ones or all-zeros codes outside a sequence, and all phase shifts come from zero bits inserted between lines. As a result, no false preamble can form at any bit phase, even while the boundary is held at a wrong phase.

// File: rtl/twa_pkg.sv
package twa_pkg;

   // Rounded-up integer division for elaboration-time sizing.
   function automatic int twa_cdiv(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/twa_offset_hunt.sv
// Input history and preamble search over every bit phase of one group.
module twa_offset_hunt
   import twa_pkg::*;
#(
   parameter int DW    = 10,
   parameter int LANES = 2,
   parameter int NG    = 3,
   localparam int IN_W  = DW * LANES,
   localparam int WIN_W = NG * IN_W,
   localparam int OFF_W = $clog2(IN_W)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IN_W-1:0]  din,
   output logic [WIN_W-1:0] win,
   output logic             hit,
   output logic [OFF_W-1:0] hit_off
);

   localparam int PRE_W = 3 * DW;
   localparam logic [PRE_W-1:0] PREAMBLE = {{(2*DW){1'b0}}, {DW{1'b1}}};

   logic [IN_W-1:0] grp [NG];

   // grp[0] newest; the window puts the oldest group in the low bits.
   for (genvar g = 0; g < NG; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst) grp[g] <= '0;
            else     grp[g] <= din;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (rst) grp[g] <= '0;
            else     grp[g] <= grp[g-1];
         end
      end
      assign win[g*IN_W +: IN_W] = grp[NG-1-g];
   end

   // Descending scan so the lowest matching phase is reported.
   always_comb begin
      hit     = 1'b0;
      hit_off = '0;
      for (int k = IN_W - 1; k >= 0; k--) begin
         if (win[k +: PRE_W] == PREAMBLE) begin
            hit     = 1'b1;
            hit_off = OFF_W'(k);
         end
      end
   end

   // R7: non-overlapping sequences are seen at exactly one phase, once.
   a_r7_single_hit: assert property (@(posedge clk) disable iff (rst)
      hit |=> !hit);

endmodule

// File: rtl/twa_realign.sv
// Word boundary register and the barrel selection of one aligned group.
module twa_realign #(
   parameter int DW    = 10,
   parameter int LANES = 2,
   parameter int NG    = 3,
   localparam int IN_W  = DW * LANES,
   localparam int WIN_W = NG * IN_W,
   localparam int OFF_W = $clog2(IN_W)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             frame_en,
   input  logic [WIN_W-1:0] win,
   input  logic             hit,
   input  logic [OFF_W-1:0] hit_off,
   output logic [IN_W-1:0]  aln
);

   logic [OFF_W-1:0] cur_off;
   logic [OFF_W-1:0] sel;

   // A new phase takes effect in the very cycle it is found.
   always_comb sel = (hit && frame_en) ? hit_off : cur_off;

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_off <= '0;
         aln     <= '0;
      end else begin
         cur_off <= sel;
         aln     <= win[sel +: IN_W];
      end
   end

   // R2: the boundary does not move while realignment is disabled.
   a_r2_hold_offset: assert property (@(posedge clk) disable iff (rst)
      !frame_en |=> $stable(cur_off));

   // R1: after an accepted detection, lane 0 carries the all-ones word.
   a_r1_lane0_ones: assert property (@(posedge clk) disable iff (rst)
      (hit && frame_en) |=> (aln[DW-1:0] == {DW{1'b1}}));

endmodule

// File: rtl/twa_flagger.sv
// Sequence marking on the aligned word stream, with look-behind and look-ahead.
module twa_flagger
   import twa_pkg::*;
#(
   parameter int DW      = 10,
   parameter int LANES   = 2,
   parameter int KIND_BIT = 6,
   localparam int IN_W   = DW * LANES
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IN_W-1:0]  aln,
   output logic [IN_W-1:0]  dout,
   output logic [LANES-1:0] trs,
   output logic [LANES-1:0] eav,
   output logic [LANES-1:0] sav
);

   localparam int AHEAD  = twa_cdiv(2, LANES);
   localparam int BEHIND = twa_cdiv(3, LANES);
   localparam int G      = AHEAD + 1 + BEHIND;
   localparam int NW     = G * LANES;
   localparam int OUT0   = BEHIND * LANES;

   logic [IN_W-1:0] hist [G-1];
   logic [DW-1:0]   vw   [NW];
   logic [NW-1:0]   st;
   logic [LANES-1:0] trs_n, eav_n, sav_n;

   for (genvar h = 0; h < G - 1; h++) begin : g_hist
      if (h == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) hist[h] <= '0;
            else     hist[h] <= aln;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) hist[h] <= '0;
            else     hist[h] <= hist[h-1];
         end
      end
   end

   // Flat word view, index 0 oldest; the newest group is aln itself.
   for (genvar g = 0; g < G; g++) begin : g_grp
      logic [IN_W-1:0] src;
      if (g == G - 1) begin : g_new
         assign src = aln;
      end else begin : g_old
         assign src = hist[G-2-g];
      end
      for (genvar j = 0; j < LANES; j++) begin : g_word
         assign vw[g*LANES+j] = src[j*DW +: DW];
      end
   end

   // st[i]: word i opens a sequence (all-ones, zero, zero).
   for (genvar i = 0; i < NW; i++) begin : g_start
      if (i + 2 < NW) begin : g_chk
         assign st[i] = (vw[i] == {DW{1'b1}}) && (vw[i+1] == '0) && (vw[i+2] == '0);
      end else begin : g_none
         assign st[i] = 1'b0;
      end
   end

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      localparam int M = OUT0 + j;
      assign trs_n[j] = |st[M -: 4];
      assign eav_n[j] = st[M-3] &  vw[M][KIND_BIT];
      assign sav_n[j] = st[M-3] & ~vw[M][KIND_BIT];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dout <= '0;
         trs  <= '0;
         eav  <= '0;
         sav  <= '0;
      end else begin
         dout <= hist[AHEAD-1];
         trs  <= trs_n;
         eav  <= eav_n;
         sav  <= sav_n;
      end
   end

   // Assertion support: two cycles of flag history.
   logic [LANES-1:0] trs_d1, trs_d2;
   always_ff @(posedge clk) begin
      if (rst) begin
         trs_d1 <= '0;
         trs_d2 <= '0;
      end else begin
         trs_d1 <= trs;
         trs_d2 <= trs_d1;
      end
   end
   logic [3*LANES-1:0] trs_hist;
   assign trs_hist = {trs, trs_d1, trs_d2};

   for (genvar j = 0; j < LANES; j++) begin : g_chk_lane
      // R3: an XYZ word closes a run of four flagged words.
      a_r3_span_four: assert property (@(posedge clk) disable iff (rst)
         (eav[j] || sav[j]) |-> (trs_hist[2*LANES+j -: 4] == 4'hF));
   end

   // R4: at most one XYZ strobe in any output group.
   a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
      $onehot0({eav, sav}));

   // R5: the first cycle after reset shows no flags.
   a_r5_clear_flags: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (trs == '0 && eav == '0 && sav == '0));

endmodule

// File: rtl/trs_word_aligner.sv
module trs_word_aligner
   import twa_pkg::*;
#(
   parameter int DW       = 10,
   parameter int LANES    = 2,
   parameter int KIND_BIT = 6
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  frame_en,
   input  logic [DW*LANES-1:0]   din,
   output logic [DW*LANES-1:0]   dout,
   output logic [LANES-1:0]      trs,
   output logic [LANES-1:0]      eav,
   output logic [LANES-1:0]      sav
);

   localparam int IN_W  = DW * LANES;
   localparam int NG    = twa_cdiv(IN_W - 1 + 3 * DW, IN_W);
   localparam int WIN_W = NG * IN_W;
   localparam int OFF_W = $clog2(IN_W);

   if (LANES < 2 || LANES > 4) begin : g_bad_lanes
      $error("trs_word_aligner: LANES must be 2..4");
   end
   if (KIND_BIT >= DW || DW < 2) begin : g_bad_width
      $error("trs_word_aligner: KIND_BIT must lie inside a word");
   end

   logic [WIN_W-1:0] win;
   logic             hit;
   logic [OFF_W-1:0] hit_off;
   logic [IN_W-1:0]  aln;

   twa_offset_hunt #(.DW(DW), .LANES(LANES), .NG(NG)) u_hunt (
      .clk     (clk),
      .rst     (rst),
      .din     (din),
      .win     (win),
      .hit     (hit),
      .hit_off (hit_off)
   );

   twa_realign #(.DW(DW), .LANES(LANES), .NG(NG)) u_realign (
      .clk      (clk),
      .rst      (rst),
      .frame_en (frame_en),
      .win      (win),
      .hit      (hit),
      .hit_off  (hit_off),
      .aln      (aln)
   );

   twa_flagger #(.DW(DW), .LANES(LANES), .KIND_BIT(KIND_BIT)) u_flag (
      .clk  (clk),
      .rst  (rst),
      .aln  (aln),
      .dout (dout),
      .trs  (trs),
      .eav  (eav),
      .sav  (sav)
   );

endmodule

// File: tb/trs_word_aligner_test.sv
module trs_word_aligner_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        frame_en = 1'b1;
   logic [19:0] din = '0;
   logic [19:0] dout;
   logic [1:0]  trs, eav, sav;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   trs_word_aligner uut (
      .clk(clk), .rst(rst), .frame_en(frame_en), .din(din),
      .dout(dout), .trs(trs), .eav(eav), .sav(sav)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   logic [19:0] m_in0, m_in1, m_in2;      // last three input groups, newest first
   logic [19:0] ap [$];                   // aligned groups as produced
   int          m_off;
   logic [19:0] e_dout;
   logic [1:0]  e_trs, e_eav, e_sav;

   function automatic logic [9:0] wd(input int n);
      logic [19:0] g;
      g = ap[n / 2];
      return g[(n % 2) * 10 +: 10];
   endfunction

   function automatic bit opens(input int n);
      return (wd(n) == 10'h3FF) && (wd(n+1) == 10'h000) && (wd(n+2) == 10'h000);
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_in0 = '0; m_in1 = '0; m_in2 = '0;
         ap.delete();
         for (int i = 0; i < 4; i++) ap.push_back(20'h0);
         m_off = 0;
         e_dout = '0; e_trs = '0; e_eav = '0; e_sav = '0;
      end else begin
         logic [59:0] bits;
         int found;
         int p;
         bits = {m_in0, m_in1, m_in2};
         found = -1;
         for (int k = 0; k < 20; k++)
            if (found < 0 && bits[k +: 30] == 30'h3FF) found = k;
         if (found >= 0 && frame_en) m_off = found;
         ap.push_back(bits[m_off +: 20]);
         m_in2 = m_in1; m_in1 = m_in0; m_in0 = din;
         p = ap.size() - 3;
         e_dout = ap[p];
         for (int j = 0; j < 2; j++) begin
            int m;
            m = 2 * p + j;
            e_trs[j] = opens(m) | opens(m-1) | opens(m-2) | opens(m-3);
            e_eav[j] = opens(m-3) &  wd(m)[6];
            e_sav[j] = opens(m-3) & ~wd(m)[6];
         end
      end
   end

   // ---------------- per-cycle comparison and event counting ----------------
   int c_eav = 0, c_sav = 0, c_trs = 0, c_x0 = 0;

   always @(negedge clk) begin
      if (!rst) begin
         chk(dout == e_dout, "R6 dout", dout, e_dout);
         chk(trs == e_trs,   "R3 trs",  trs,  e_trs);
         chk(eav == e_eav,   "R4 eav",  eav,  e_eav);
         chk(sav == e_sav,   "R4 sav",  sav,  e_sav);
         c_eav += $countones(eav);
         c_sav += $countones(sav);
         c_trs += $countones(trs);
         c_x0  += int'(eav[0] | sav[0]);
      end
   end

   // ---------------- stimulus ----------------
   bit bq [$];

   task automatic put_word(input logic [9:0] w);
      for (int b = 0; b < 10; b++) bq.push_back(w[b]);
   endtask

   task automatic put_zero_bits(input int n);
      for (int b = 0; b < n; b++) bq.push_back(1'b0);
   endtask

   task automatic put_line();
      put_word(10'h3FF); put_word(10'h000); put_word(10'h000); put_word(10'h274);
      for (int i = 0; i < 6; i++) put_word(10'h040);
      put_word(10'h3FF); put_word(10'h000); put_word(10'h000); put_word(10'h200);
      for (int i = 0; i < 8; i++) put_word((i % 2 == 0) ? 10'h2AA : 10'h155);
   endtask

   task automatic drive_avail();
      while (bq.size() >= 20) begin
         logic [19:0] v;
         for (int b = 0; b < 20; b++) v[b] = bq.pop_front();
         din = v;
         @(negedge clk);
      end
   endtask

   task automatic flush();
      put_zero_bits(160);
      drive_avail();
   endtask

   initial begin
      #(2_000_000);
      n_fail++;
      $display("FAIL R6 watchdog actual=timeout expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      int b_eav, b_sav, b_trs, b_x0;
      repeat (3) @(negedge clk);
      // R5: reset state
      chk(dout == '0, "R5 reset dout", dout, 0);
      chk(trs == '0 && eav == '0 && sav == '0, "R5 reset flags", {trs, eav, sav}, 0);
      rst = 1'b0;
      @(negedge clk);

      // R1: 7-bit phase, realignment enabled
      frame_en = 1'b1;
      b_eav = c_eav; b_sav = c_sav; b_trs = c_trs;
      put_zero_bits(7);
      for (int i = 0; i < 3; i++) put_line();
      flush();
      chk(c_eav - b_eav == 3, "R1 eav after realign", c_eav - b_eav, 3);
      chk(c_sav - b_sav == 3, "R4 sav count", c_sav - b_sav, 3);
      chk(c_trs - b_trs == 24, "R3 trs word count", c_trs - b_trs, 24);

      // R2: shift by 5 bits with realignment disabled
      frame_en = 1'b0;
      b_eav = c_eav; b_sav = c_sav; b_trs = c_trs;
      put_zero_bits(5);
      for (int i = 0; i < 2; i++) put_line();
      flush();
      chk(c_trs - b_trs == 0, "R2 no flags while held", c_trs - b_trs, 0);
      chk(c_eav + c_sav - b_eav - b_sav == 0, "R2 no strobes while held", c_eav + c_sav - b_eav - b_sav, 0);

      // R1: enabling again recovers the new phase
      frame_en = 1'b1;
      b_eav = c_eav;
      for (int i = 0; i < 2; i++) put_line();
      flush();
      chk(c_eav - b_eav == 2, "R1 recover after enable", c_eav - b_eav, 2);

      // R8: one-word shift while held, XYZ moves to lane 0
      frame_en = 1'b0;
      b_eav = c_eav; b_x0 = c_x0;
      put_zero_bits(10);
      for (int i = 0; i < 2; i++) put_line();
      flush();
      chk(c_eav - b_eav == 2, "R8 flagged at word shift", c_eav - b_eav, 2);
      chk(c_x0 - b_x0 == 4, "R8 XYZ in lane 0", c_x0 - b_x0, 4);

      // R7: step the bit phase through every offset
      frame_en = 1'b1;
      b_eav = c_eav;
      for (int d = 0; d < 20; d++) begin
         put_zero_bits(1);
         put_line();
      end
      flush();
      chk(c_eav - b_eav == 20, "R7 every bit phase", c_eav - b_eav, 20);

      // R5: reset mid-run, then word-aligned data at offset zero while held
      rst = 1'b1;
      bq.delete();
      din = '0;
      @(negedge clk);
      @(negedge clk);
      chk(dout == '0 && trs == '0 && eav == '0 && sav == '0, "R5 reset again", {dout, trs, eav, sav}, 0);
      rst = 1'b0;
      frame_en = 1'b0;
      b_eav = c_eav; b_sav = c_sav;
      put_line();
      flush();
      chk(c_eav - b_eav == 1, "R5 offset zero eav", c_eav - b_eav, 1);
      chk(c_sav - b_sav == 1, "R5 offset zero sav", c_sav - b_sav, 1);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule